// File: doc/BRIEF.md
# Four-Level UART Interrupt Prioritizer

This block collects the four interrupt conditions of a UART: a receiver line error (overrun, parity, framing or break), received data ready, transmit holding register empty, and a modem status change. Each condition arrives as a one-cycle event pulse and is held in its own pending latch. A write-only enable register masks the latches, and a single active-high request output is raised while any enabled source is pending.

The processor reads an identification byte to learn which enabled source has the highest priority. Each source is cleared by the bus access that services it. The line-status and modem-status registers sit outside the block. The block sees only the bus strobes and address that read them.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the enable register is 0, all four pending latches are 0, `irqOut` is low and the identification byte reads 0x01.
- R2: An event pulse sets its pending latch on the next clock edge. When a set and a clear of the same latch fall in the same cycle, the set wins.
- R3: A write at address 1 loads the enable register. Bit 0 enables received data, bit 1 enables holding register empty, bit 2 enables line status and bit 3 enables modem status. Bits 7:4 are ignored. `irqOut` is high exactly when some pending source is enabled.
- R4: A read at address 2 returns the identification byte. Bit 0 is 0 when an enabled source is pending and 1 otherwise. Bits 2:1 name the winning source: 11 for line status, 10 for data ready, 01 for holding register empty, 00 for modem status. The priority order is line, then data ready, then holding register empty, then modem. Bits 7:3 read 0.
- R5: A read at address 5 (line status) clears the line-status latch.
- R6: A read at address 0 (receive buffer) clears the data-ready latch.
- R7: The holding-register-empty latch clears on a write at address 0. It also clears on a read at address 2 while that source is the one reported. A read at address 2 while another source is reported leaves it pending.
- R8: A read at address 6 (modem status) clears the modem-status latch.
- R9: Clearing an enable bit removes its source from arbitration on the next cycle. The pending latch is kept, and the source is reported again once it is re-enabled.
- R10: `busRdData` is 0 at every address other than 2. The enable register cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineErrEvt | input | 1 | Line error event pulse |
| rxReadyEvt | input | 1 | Received data ready event pulse |
| thrEmptyEvt | input | 1 | Holding register empty event pulse |
| modemChgEvt | input | 1 | Modem status change event pulse |
| busRd | input | 1 | Bus read strobe |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (identification byte at address 2) |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: a 3-bit address, an 8-bit data bus and the default register addresses. With these values every bus access that services a source can be reached, along with the single read-back location. A table sweeps combinations of events and enable masks through the priority encoder. Directed tests then cover the conditional clear of the holding-register-empty latch, a set and a clear in the same cycle, masking with retention, the ignored upper enable bits, and reads at addresses other than 2.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 4;
  localparam int SRC_LINE  = 0;
  localparam int SRC_RX    = 1;
  localparam int SRC_THR   = 2;
  localparam int SRC_MODEM = 3;

  typedef struct packed {
    logic rbrRead;
    logic thrWrite;
    logic enWrite;
    logic idRead;
    logic lineRead;
    logic modemRead;
  } busStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int RBR_ADDR = 0,
  parameter int EN_ADDR  = 1,
  parameter int ID_ADDR  = 2,
  parameter int LSR_ADDR = 5,
  parameter int MSR_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] idByte,
  output busStrobe_t        stb,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [ADDR_W-1:0] A_RBR = ADDR_W'(RBR_ADDR);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(ID_ADDR);
  localparam logic [ADDR_W-1:0] A_LSR = ADDR_W'(LSR_ADDR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_ADDR);

  always_comb begin
    stb.rbrRead   = busRd && (busAddr == A_RBR);
    stb.thrWrite  = busWr && (busAddr == A_RBR);
    stb.enWrite   = busWr && (busAddr == A_EN);
    stb.idRead    = busRd && (busAddr == A_ID);
    stb.lineRead  = busRd && (busAddr == A_LSR);
    stb.modemRead = busRd && (busAddr == A_MSR);
  end

  assign busRdData = (busAddr == A_ID) ? idByte : '0;

  // R10: nothing but the identification byte is visible on the read bus
  a_r10_rd_only_id: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != A_ID) |-> (busRdData == '0));
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NSRC-1:0]   srcEvt,
  output logic [DATA_W-1:0] idByte,
  output logic              irqOut
);
  logic [NSRC-1:0] enReg;
  logic [NSRC-1:0] srcEn;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] masked;
  logic [NSRC-1:0] clr;
  logic [1:0]      topIdx;
  logic            hit;

  always_ff @(posedge clk) begin
    if (!rstN)            enReg <= '0;
    else if (stb.enWrite) enReg <= wrData[NSRC-1:0];
  end

  // enable bit layout differs from the priority order
  assign srcEn = {enReg[3], enReg[0], enReg[1], enReg[2]} ;

  assign masked = pend & {srcEn[3], srcEn[1], srcEn[2], srcEn[0]};

  always_comb begin
    topIdx = 2'd0;
    hit    = |masked;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (masked[i]) topIdx = 2'(i);
    end
  end

  always_comb begin
    idByte      = '0;
    idByte[0]   = !hit;
    idByte[2:1] = hit ? 2'(2'd3 - topIdx) : 2'b00;
  end

  assign irqOut = hit;

  always_comb begin
    clr[SRC_LINE]  = stb.lineRead;
    clr[SRC_RX]    = stb.rbrRead;
    clr[SRC_THR]   = stb.thrWrite || (stb.idRead && hit && (topIdx == 2'(SRC_THR)));
    clr[SRC_MODEM] = stb.modemRead;
  end

  for (genvar g = 0; g < NSRC; g++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN)          pend[g] <= 1'b0;
      else if (srcEvt[g]) pend[g] <= 1'b1;
      else if (clr[g])    pend[g] <= 1'b0;
    end
  end

  // R2: an event always lands, even against a clear
  a_r2_line_set: assert property (@(posedge clk) disable iff (!rstN)
    srcEvt[SRC_LINE] |=> pend[SRC_LINE]);
  // R4: line errors outrank everything when enabled
  a_r4_line_top: assert property (@(posedge clk) disable iff (!rstN)
    (pend[SRC_LINE] && enReg[2]) |-> (idByte[2:1] == 2'b11 && irqOut));
  // R5: line-status read clears
  a_r5_line_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lineRead && !srcEvt[SRC_LINE]) |=> !pend[SRC_LINE]);
  // R6: receive buffer read clears
  a_r6_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rbrRead && !srcEvt[SRC_RX]) |=> !pend[SRC_RX]);
  // R7: holding register write clears
  a_r7_thr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.thrWrite && !srcEvt[SRC_THR]) |=> !pend[SRC_THR]);
  // R8: modem-status read clears
  a_r8_modem_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.modemRead && !srcEvt[SRC_MODEM]) |=> !pend[SRC_MODEM]);
  // R9: an empty enable register leaves the request low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irqOut);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int RBR_ADDR = 0,
  parameter int EN_ADDR  = 1,
  parameter int ID_ADDR  = 2,
  parameter int LSR_ADDR = 5,
  parameter int MSR_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineErrEvt,
  input  logic              rxReadyEvt,
  input  logic              thrEmptyEvt,
  input  logic              modemChgEvt,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  busStrobe_t      stb;
  logic [DATA_W-1:0] idByte;
  logic [NSRC-1:0]   srcEvt;

  assign srcEvt = {modemChgEvt, thrEmptyEvt, rxReadyEvt, lineErrEvt};

  irq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RBR_ADDR(RBR_ADDR), .EN_ADDR(EN_ADDR),
    .ID_ADDR(ID_ADDR), .LSR_ADDR(LSR_ADDR), .MSR_ADDR(MSR_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .idByte(idByte), .stb(stb), .busRdData(busRdData)
  );

  irq_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .srcEvt(srcEvt),
    .idByte(idByte), .irqOut(irqOut)
  );

  // R1/R4: request and "none pending" bit are always opposite
  a_r4_id_vs_irq: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != idByte[0]));
endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineErrEvt = 0, rxReadyEvt = 0, thrEmptyEvt = 0, modemChgEvt = 0;
  logic busRd = 0, busWr = 0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic irqOut;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_prio u0 (
    .clk(clk), .rstN(rstN), .lineErrEvt(lineErrEvt), .rxReadyEvt(rxReadyEvt),
    .thrEmptyEvt(thrEmptyEvt), .modemChgEvt(modemChgEvt), .busRd(busRd),
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  // {events[3:0] = modem,thr,rx,line ; enable[3:0] = modem,line,thr,rx ; expected id}
  localparam logic [15:0] VEC [12] = '{
    {4'b0000, 4'b1111, 8'h01}, {4'b0001, 4'b1111, 8'h06},
    {4'b0010, 4'b1111, 8'h04}, {4'b0100, 4'b1111, 8'h02},
    {4'b1000, 4'b1111, 8'h00}, {4'b1111, 4'b1111, 8'h06},
    {4'b1110, 4'b1111, 8'h04}, {4'b1100, 4'b1111, 8'h02},
    {4'b1111, 4'b1011, 8'h04}, {4'b1111, 4'b1000, 8'h00},
    {4'b0111, 4'b1000, 8'h01}, {4'b1111, 4'b0000, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic rd, input logic wr, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWrData = d;
    @(negedge clk);
    busRd = 0; busWr = 0; busAddr = 3'd7; busWrData = '0;
  endtask

  task automatic readId(output logic [7:0] v);
    @(negedge clk);
    busRd = 1; busAddr = 3'd2;
    #1 v = busRdData;
    @(negedge clk);
    busRd = 0; busAddr = 3'd7;
  endtask

  task automatic pulseEvt(input logic [3:0] e);
    @(negedge clk);
    {modemChgEvt, thrEmptyEvt, rxReadyEvt, lineErrEvt} = e;
    @(negedge clk);
    {modemChgEvt, thrEmptyEvt, rxReadyEvt, lineErrEvt} = '0;
  endtask

  task automatic clearAll();
    busOp(1, 0, 3'd5, 0);
    busOp(1, 0, 3'd0, 0);
    busOp(1, 0, 3'd6, 0);
    busOp(0, 1, 3'd0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    busAddr = 3'd7;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    readId(v);
    check("R1 id", v, 8'h01);
    check("R1 irq", {7'd0, irqOut}, 8'h00);

    // R3/R4 table sweep
    for (int k = 0; k < 12; k++) begin
      busOp(0, 1, 3'd1, {4'h0, VEC[k][11:8]});
      pulseEvt(VEC[k][15:12]);
      readIdNoClear(v);
      check($sformatf("R4 vec%0d id", k), v, VEC[k][7:0]);
      check($sformatf("R3 vec%0d irq", k), {7'd0, irqOut}, {7'd0, ~VEC[k][0]});
      clearAll();
    end

    // R5 R6 R8 individual clears, all enabled
    busOp(0, 1, 3'd1, 8'h0F);
    pulseEvt(4'b1011);
    busOp(1, 0, 3'd5, 0);
    readIdNoClear(v); check("R5 line cleared, rx next", v, 8'h04);
    busOp(1, 0, 3'd0, 0);
    readIdNoClear(v); check("R6 rx cleared, modem next", v, 8'h00);
    busOp(1, 0, 3'd6, 0);
    readIdNoClear(v); check("R8 modem cleared", v, 8'h01);

    // R7 id read while rx reported leaves thr; id read on thr clears it
    pulseEvt(4'b0110);
    readId(v); check("R7 rx reported", v, 8'h04);
    busOp(1, 0, 3'd0, 0);
    readId(v); check("R7 thr still pending", v, 8'h02);
    readId(v); check("R7 thr cleared by id read", v, 8'h01);
    pulseEvt(4'b0100);
    busOp(0, 1, 3'd0, 8'h55);
    readIdNoClear(v); check("R7 thr cleared by write", v, 8'h01);

    // R2 set wins over same-cycle clear
    @(negedge clk);
    lineErrEvt = 1; busRd = 1; busAddr = 3'd5;
    @(negedge clk);
    lineErrEvt = 0; busRd = 0; busAddr = 3'd7;
    readIdNoClear(v); check("R2 set beats clear", v, 8'h06);
    clearAll();

    // R9 mask keeps pending, re-enable shows it
    pulseEvt(4'b0001);
    busOp(0, 1, 3'd1, 8'h00);
    check("R9 masked irq low", {7'd0, irqOut}, 8'h00);
    busOp(0, 1, 3'd1, 8'h04);
    readIdNoClear(v); check("R9 reappears", v, 8'h06);
    clearAll();

    // R3 upper enable bits ignored
    pulseEvt(4'b1111);
    busOp(0, 1, 3'd1, 8'hF0);
    check("R3 upper bits ignored", {7'd0, irqOut}, 8'h00);

    // R10 other addresses read 0 (enable not readable)
    busOp(0, 1, 3'd1, 8'h0F);
    @(negedge clk);
    busAddr = 3'd1; busRd = 1;
    #1 check("R10 enable not readable", busRdData, 8'h00);
    busAddr = 3'd3;
    #1 check("R10 addr3 reads 0", busRdData, 8'h00);
    @(negedge clk);
    busRd = 0; busAddr = 3'd7;
    finishRun();
  end

  // id sample without a read strobe (addr 2 drives the mux, no clear side effect)
  task automatic readIdNoClear(output logic [7:0] v);
    @(negedge clk);
    busAddr = 3'd2;
    #1 v = busRdData;
    busAddr = 3'd7;
  endtask
endmodule